// File: doc/BRIEF.md
# Traffic-Aware Link Frequency Controller

This block decides how fast one network-on-chip link runs. It works as a small control machine that cycles through four steps. First it accepts a requested traffic class. Next it counts the valid flits on the link over a control window of programmable length. It then issues a traffic ID, and finally it applies a clock-boost setting. The boost setting comes from a frequency-selection table indexed by the traffic ID and by one comparison: whether the counted traffic exceeded a threshold.

Logic outside this block turns the boost code into a 1x, 2x or 4x link clock. The single-cycle update strobe tells that logic when a new setting is valid. Between updates the boost code and the traffic ID do not change.

Top module: `link_freq_ctrl`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises, traffic_id_o is 0, boost_sel_o is 00 (1x) and freq_upd_o is 0. The machine starts in its select step.
- R2: class_req_i values 0..3 request classes t1..t4 and are valid. Any value with bit 2 set is not valid. In the select step, a request that is not valid keeps the machine in the select step, no strobe is issued and both outputs stay unchanged.
- R3: The steps always run in this order: select, observe, send, apply, then back to select. A valid request is accepted on clock edge e0. The observe step covers the following L edges. At edge L+1 the outputs are updated and freq_upd_o rises. At edge L+2 the machine is back in select.
- R4: The window length L is window_len_i clamped to the range 8..128. It is sampled at the accepting edge.
- R5: The traffic count is the number of observe-step edges at which flit_vld_i is 1. Flits seen in any other step are not counted.
- R6: A count strictly greater than threshold_i selects the high range. A count equal to or below threshold_i selects the low range.
- R7: With the default table, the low range gives t1 and t2 the code 00 (1x) and t3 and t4 the code 01 (2x). The high range gives t1 the code 01 (2x) and t2, t3 and t4 the code 10 (4x).
- R8: A table entry of 11 is reserved and is output as 00 (1x). boost_sel_o never shows 11.
- R9: freq_upd_o is a one-cycle pulse and is issued only in the apply step. boost_sel_o changes only in a cycle where freq_upd_o is high, and holds its value until the next apply step.
- R10: If class_req_i is not valid at the last observe edge, the machine returns to select without sending an ID. No strobe follows and the outputs stay unchanged.
- R11: traffic_id_o takes the 2-bit class code that was accepted at e0, and it changes only together with freq_upd_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base link clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flit_vld_i | input | 1 | High in each cycle that carries a valid flit |
| class_req_i | input | 3 | Requested traffic class; bit 2 set means not valid |
| window_len_i | input | 8 | Control window length in cycles, before clamping |
| threshold_i | input | 8 | Traffic threshold for choosing the range |
| traffic_id_o | output | 2 | Traffic ID last sent to the table |
| boost_sel_o | output | 2 | Boost code: 00 is 1x, 01 is 2x, 10 is 4x |
| freq_upd_o | output | 1 | One-cycle pulse when a new boost code is applied |

## Verification
The flit patterns used fill the window completely, leave it empty, or fill only part of it. Some patterns also drive flits before the window opens and after it closes. Comparing the results shows whether only observe-step flits are counted.

Setting the count exactly at the threshold and then one above it separates a strict comparison from a non-strict one. Window lengths below 8, inside the range and above 128 are checked through the measured cycle delay until the strobe, which shows the clamping.

Invalid requests held in the select step, and a request withdrawn during the observe step, show that the machine returns to select without producing a strobe. A second instance, built with a reserved code in its table, shows how that code is decoded.

// File: rtl/lfc_pkg.sv
`timescale 1ns/1ps
package lfc_pkg;

  typedef enum logic [1:0] {
    ST_SEL   = 2'd0,
    ST_OBS   = 2'd1,
    ST_SEND  = 2'd2,
    ST_APPLY = 2'd3
  } lfc_state_e;

  localparam logic [1:0] BOOST_1X  = 2'b00;
  localparam logic [1:0] BOOST_2X  = 2'b01;
  localparam logic [1:0] BOOST_4X  = 2'b10;
  localparam logic [1:0] BOOST_RSV = 2'b11;

  // reserved code falls back to base clock
  function automatic logic [1:0] boost_decode(input logic [1:0] raw);
    return (raw == BOOST_RSV) ? BOOST_1X : raw;
  endfunction

endpackage

// File: rtl/lfc_window_cnt.sv
`timescale 1ns/1ps
module lfc_window_cnt #(
  parameter int WIN_MIN = 8,
  parameter int WIN_MAX = 128,
  localparam int CNT_W  = $clog2(WIN_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             obs_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             flit_i,
  output logic             last_o,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] MIN_C = CNT_W'(WIN_MIN);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(WIN_MAX);

  logic [CNT_W-1:0] len_q, tick_q, cnt_q, lat_q;
  logic [CNT_W-1:0] len_clamped, total;

  always_comb begin
    if (len_i < MIN_C)      len_clamped = MIN_C;
    else if (len_i > MAX_C) len_clamped = MAX_C;
    else                    len_clamped = len_i;
  end

  assign last_o = obs_i && ((tick_q + 1'b1) == len_q);
  assign total  = cnt_q + CNT_W'(flit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q  <= MIN_C;
      tick_q <= '0;
      cnt_q  <= '0;
      lat_q  <= '0;
    end else if (start_i) begin
      len_q  <= len_clamped;
      tick_q <= '0;
      cnt_q  <= '0;
    end else if (obs_i) begin
      if (last_o) begin
        lat_q  <= total;
        tick_q <= '0;
        cnt_q  <= '0;
      end else begin
        tick_q <= tick_q + 1'b1;
        cnt_q  <= total;
      end
    end
  end

  assign count_o = lat_q;

endmodule

// File: rtl/lfc_freq_table.sv
`timescale 1ns/1ps
module lfc_freq_table
  import lfc_pkg::*;
#(
  parameter logic [15:0] FREQ_MAP = 16'hA950
) (
  input  logic [1:0] cls_i,
  input  logic       above_i,
  output logic [1:0] boost_o
);

  localparam int N_ENT = 8;

  logic [1:0] ent [N_ENT];
  logic [2:0] idx;

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    assign ent[g] = FREQ_MAP[2*g +: 2];
  end

  assign idx     = {above_i, cls_i};
  assign boost_o = boost_decode(ent[idx]);

endmodule

// File: rtl/lfc_seq_fsm.sv
`timescale 1ns/1ps
module lfc_seq_fsm
  import lfc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] class_req_i,
  input  logic       last_i,
  output logic       start_o,
  output logic       obs_o,
  output logic       send_o,
  output logic       apply_o,
  output logic [1:0] cls_o,
  output lfc_state_e state_o
);

  lfc_state_e state_q, state_d;
  logic [1:0] cls_q;
  logic       req_ok;

  assign req_ok = ~class_req_i[2];

  always_comb begin
    state_d = state_q;
    start_o = 1'b0;
    unique case (state_q)
      ST_SEL: if (req_ok) begin
        state_d = ST_OBS;
        start_o = 1'b1;
      end
      ST_OBS: if (last_i) state_d = req_ok ? ST_SEND : ST_SEL;
      ST_SEND:  state_d = ST_APPLY;
      ST_APPLY: state_d = ST_SEL;
      default:  state_d = ST_SEL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SEL;
      cls_q   <= '0;
    end else begin
      state_q <= state_d;
      if (start_o) cls_q <= class_req_i[1:0];
    end
  end

  assign obs_o   = (state_q == ST_OBS);
  assign send_o  = (state_q == ST_SEND);
  assign apply_o = (state_q == ST_APPLY);
  assign cls_o   = cls_q;
  assign state_o = state_q;

endmodule

// File: rtl/link_freq_ctrl.sv
`timescale 1ns/1ps
module link_freq_ctrl
  import lfc_pkg::*;
#(
  parameter int          WIN_MIN  = 8,
  parameter int          WIN_MAX  = 128,
  parameter logic [15:0] FREQ_MAP = 16'hA950,
  localparam int         CNT_W    = $clog2(WIN_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flit_vld_i,
  input  logic [2:0]       class_req_i,
  input  logic [CNT_W-1:0] window_len_i,
  input  logic [CNT_W-1:0] threshold_i,
  output logic [1:0]       traffic_id_o,
  output logic [1:0]       boost_sel_o,
  output logic             freq_upd_o
);

  logic             start, obs, send, apply, last;
  logic [1:0]       cls;
  lfc_state_e       seq_state;
  logic [CNT_W-1:0] win_count;
  logic             above;
  logic [1:0]       tbl_boost;
  logic [1:0]       id_q, boost_q;

  lfc_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .class_req_i (class_req_i),
    .last_i      (last),
    .start_o     (start),
    .obs_o       (obs),
    .send_o      (send),
    .apply_o     (apply),
    .cls_o       (cls),
    .state_o     (seq_state)
  );

  lfc_window_cnt #(.WIN_MIN(WIN_MIN), .WIN_MAX(WIN_MAX)) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .obs_i   (obs),
    .len_i   (window_len_i),
    .flit_i  (flit_vld_i),
    .last_o  (last),
    .count_o (win_count)
  );

  assign above = (win_count > threshold_i);

  lfc_freq_table #(.FREQ_MAP(FREQ_MAP)) u_tbl (
    .cls_i   (cls),
    .above_i (above),
    .boost_o (tbl_boost)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q    <= '0;
      boost_q <= BOOST_1X;
    end else if (send) begin
      id_q    <= cls;
      boost_q <= tbl_boost;
    end
  end

  assign traffic_id_o = id_q;
  assign boost_sel_o  = boost_q;
  assign freq_upd_o   = apply;

endmodule

// File: rtl/lfc_checker.sv
`timescale 1ns/1ps
module lfc_checker
  import lfc_pkg::*;
#(
  parameter int WIN_MAX = 128,
  localparam int CNT_W  = $clog2(WIN_MAX + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       class_req_i,
  input lfc_state_e       state_i,
  input logic [CNT_W-1:0] count_i,
  input logic [1:0]       traffic_id_o,
  input logic [1:0]       boost_sel_o,
  input logic             freq_upd_o
);

  a_r9_upd_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freq_upd_o |=> !freq_upd_o);

  a_r9_boost_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boost_sel_o != $past(boost_sel_o)) |-> freq_upd_o);

  a_r11_id_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (traffic_id_o != $past(traffic_id_o)) |-> freq_upd_o);

  a_r8_no_rsv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boost_sel_o != BOOST_RSV);

  a_r5_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= CNT_W'(WIN_MAX));

  a_r3_send_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_SEND) |=> (state_i == ST_APPLY) && freq_upd_o);

  a_r3_apply_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_APPLY) |=> (state_i == ST_SEL));

  a_r2_invalid_stay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_SEL && class_req_i[2]) |=> (state_i == ST_SEL));

endmodule

bind link_freq_ctrl lfc_checker #(.WIN_MAX(WIN_MAX)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .class_req_i  (class_req_i),
  .state_i      (seq_state),
  .count_i      (win_count),
  .traffic_id_o (traffic_id_o),
  .boost_sel_o  (boost_sel_o),
  .freq_upd_o   (freq_upd_o)
);

// File: tb/tb_link_freq_ctrl.sv
`timescale 1ns/1ps
module tb_link_freq_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flit = 1'b0;
  logic [2:0] cls_req = 3'b100;
  logic [7:0] win = 8'd8;
  logic [7:0] thr = 8'd0;
  logic [1:0] id, boost, id_r, boost_r;
  logic       upd, upd_r;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  link_freq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .flit_vld_i(flit), .class_req_i(cls_req),
    .window_len_i(win), .threshold_i(thr),
    .traffic_id_o(id), .boost_sel_o(boost), .freq_upd_o(upd)
  );

  // t1 low-range entry holds the reserved code
  link_freq_ctrl #(.FREQ_MAP(16'hA953)) dut_rsv (
    .clk_i(clk), .rst_ni(rst_n), .flit_vld_i(flit), .class_req_i(cls_req),
    .window_len_i(win), .threshold_i(thr),
    .traffic_id_o(id_r), .boost_sel_o(boost_r), .freq_upd_o(upd_r)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_map(input logic [1:0] c, input bit hi);
    if (!hi) return (c < 2) ? 2'b00 : 2'b01;
    return (c == 0) ? 2'b01 : 2'b10;
  endfunction

  task automatic run_case(input logic [1:0] c, input int len, input int k,
                          input int th, input bit extra, input string req);
    int l, cnt, n;
    bit seen;
    logic [1:0] eb, ebr;
    l   = (len < 8) ? 8 : ((len > 128) ? 128 : len);
    cnt = (k < l) ? k : l;
    eb  = exp_map(c, cnt > th);
    ebr = (c == 0 && !(cnt > th)) ? 2'b00 : eb;
    @(negedge clk);
    win = 8'(len); thr = 8'(th); flit = extra; cls_req = {1'b0, c};
    @(posedge clk);
    n = 0; seen = 0;
    while (!seen && n < 400) begin
      @(negedge clk);
      n++;
      if (upd) seen = 1;
      else flit = (n <= k) || (extra && n > l);
    end
    chk(seen && n == l + 2, {req, " R3 R4 latency"}, n, l + 2);
    chk(id == c, "R11 traffic id", id, c);
    chk(boost == eb, {req, " R5 R6 R7 boost"}, boost, eb);
    chk(boost_r == ebr, "R8 reserved decode", boost_r, ebr);
    cls_req = 3'b100; flit = 0;
    @(negedge clk);
    chk(!upd, "R9 strobe width", upd, 0);
    chk(boost == eb, "R9 boost hold", boost, eb);
    repeat (3) @(negedge clk);
  endtask

  task automatic invalid_hold();
    logic [1:0] b0, i0;
    int hits;
    b0 = boost; i0 = id; hits = 0;
    for (int j = 0; j < 120; j++) begin
      @(negedge clk);
      cls_req = 3'(4 + (j % 4)); flit = 1;
      if (upd) hits++;
    end
    chk(hits == 0, "R2 no strobe on invalid class", hits, 0);
    chk(boost == b0 && id == i0, "R2 outputs unchanged", {id, boost}, {i0, b0});
    cls_req = 3'b100; flit = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic abort_case();
    logic [1:0] b0, i0;
    int hits;
    b0 = boost; i0 = id; hits = 0;
    @(negedge clk);
    win = 8'd8; thr = 8'd0; cls_req = 3'b011;
    @(posedge clk);
    @(negedge clk);
    cls_req = 3'b110; flit = 1;
    for (int j = 0; j < 200; j++) begin
      @(negedge clk);
      if (upd) hits++;
    end
    chk(hits == 0, "R10 abort no strobe", hits, 0);
    chk(boost == b0 && id == i0, "R10 outputs unchanged", {id, boost}, {i0, b0});
    flit = 0; cls_req = 3'b100;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(id == 0 && boost == 0 && !upd, "R1 reset state", {id, boost, upd}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(id == 0 && boost == 0 && !upd, "R1 after release", {id, boost, upd}, 0);
    invalid_hold();
    run_case(2'd0, 8,   0,   0,   0, "R6 empty window");
    run_case(2'd3, 20,  15,  10,  0, "R5 partial fill");
    run_case(2'd2, 3,   8,   7,   1, "R4 short clamp with outside flits");
    run_case(2'd1, 200, 128, 127, 0, "R4 long clamp");
    run_case(2'd2, 8,   5,   5,   0, "R6 count equals threshold");
    run_case(2'd2, 8,   6,   5,   1, "R6 count above threshold");
    run_case(2'd0, 16,  9,   3,   0, "R7 t1 high");
    run_case(2'd1, 12,  2,   4,   0, "R7 t2 low");
    abort_case();
    run_case(2'd3, 9,   0,   0,   0, "R3 after abort");
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

endmodule